// File: doc/BRIEF.md
# Single-Wire Debug Bit Transmitter

This block is the target side of a single-wire, open-drain debug line. It returns a 16-bit read word to an external host one bit at a time. The host opens every bit time by pulling the shared line low. The block brings the line through a synchroniser into its own serial clock domain, detects the falling edge, and then closes the bit itself. For a 0 it holds the line low for a counted interval. For a 1 it leaves the line alone. In both cases it ends the bit with a single-cycle active-high speedup drive and then releases the line to high impedance.

A word is loaded with a start pulse and goes out most significant bit first. Between bits the block re-arms only once the line reads high again. After the sixteenth bit it returns to idle and raises a done flag. The line pin is modelled as two outputs: a drive enable and a drive value. When the enable is low, the line is released and an external pull-up holds it high.

Top module: `dbg_bit_tx`

## Requirements
- R1: The line input passes through a two-flop synchroniser and a falling-edge detector. If the host pulls the line low just after clock edge k-1, the edge at k samples the low level and the bit start is taken at edge k+2. Drive begins after that edge, and never without a detected falling edge.
- R2: For a 0 bit the block drives the line low (line_oe_o=1, line_do_o=0) for exactly 13 clock cycles, starting at the bit start.
- R3: Every bit ends with exactly one cycle of active-high drive (line_oe_o=1, line_do_o=1). After that cycle line_oe_o is 0.
- R4: For a 1 bit the block never drives low. The speedup cycle falls in the first cycle after the bit start.
- R5: About 10 cycles after the host pulls the line low, the line level equals the bit being sent.
- R6: A falling edge on the line while the block is driving, during the low hold or during the speedup cycle, starts no new bit. Exactly one bit is sent per bit time that the host opens.
- R7: After releasing the line, the block ignores the line until the synchronised line reads high. Only then does it arm for the next falling edge. A host that holds the line low for a long time gets no extra drive.
- R8: The word is sent from bit 15 down to bit 0, one bit per host-opened bit time.
- R9: busy_o is 1 from the cycle after a start pulse until the last speedup cycle. done_o rises when that last speedup cycle ends and clears on the next accepted start.
- R10: A start pulse while busy_o is 1 is ignored. The word in flight continues unchanged.
- R11: After reset, line_oe_o, line_do_o, busy_o and done_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock of the target |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Level read back from the shared line, asynchronous |
| start_i | input | 1 | Load word_i and begin a word (accepted only when idle) |
| word_i | input | 16 | Word to return to the host |
| line_oe_o | output | 1 | 1 drives the line, 0 releases it |
| line_do_o | output | 1 | Value driven while line_oe_o is 1 |
| busy_o | output | 1 | A word is being sent |
| done_o | output | 1 | Last word sent completely |

## Verification
Two functions can coincide. The speedup drive that closes a 0 bit can meet a host falling edge, and the low hold can meet a host that releases and pulls the line again. The bench provokes both inside one word: it pulls the line low during the low hold and again during the speedup cycle of the same 0 bit. It then judges that the block releases the line on schedule, drives nothing more through the following idle stretch, and sends the next bit of the word with exact timing.

// File: rtl/dbgtx_pkg.sv
package dbgtx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_WAIT,
    ST_LOW,
    ST_SPEED
  } tx_state_e;
endpackage

// File: rtl/dbgtx_line_sync.sv
module dbgtx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_s_o,
  output logic fall_o
);
  // stages plus one history flop for edge detection
  logic [STAGES:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '1;
    else         q <= {q[STAGES-1:0], line_i};
  end

  assign line_s_o = q[STAGES-1];
  assign fall_o   = q[STAGES] & ~q[STAGES-1];
endmodule

// File: rtl/dbgtx_shifter.sv
module dbgtx_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              shift_i,
  output logic              bit_o,
  output logic              last_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= word_i;
      cnt_q <= CNT_W'(WORD_W);
    end else if (shift_i) begin
      sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign bit_o  = sh_q[WORD_W-1];
  assign last_o = (cnt_q == CNT_W'(1));

  assert_load_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> cnt_q == '0);
  assert_shift_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> cnt_q != '0);
endmodule

// File: rtl/dbgtx_fsm.sv
module dbgtx_fsm
  import dbgtx_pkg::*;
#(
  parameter int LOW_CYC = 13
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic line_s_i,
  input  logic fall_i,
  input  logic bit_i,
  input  logic last_i,
  output logic load_o,
  output logic shift_o,
  output logic oe_o,
  output logic do_o,
  output logic busy_o,
  output logic done_o
);
  localparam int TMR_W = (LOW_CYC > 2) ? $clog2(LOW_CYC) : 1;

  tx_state_e        state_q, state_d;
  logic [TMR_W-1:0] tmr_q;
  logic             done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_ARM;
      ST_ARM:   if (line_s_i) state_d = ST_WAIT;
      ST_WAIT:  if (fall_i) state_d = bit_i ? ST_SPEED : ST_LOW;
      ST_LOW:   if (tmr_q == TMR_W'(LOW_CYC - 1)) state_d = ST_SPEED;
      ST_SPEED: state_d = last_i ? ST_IDLE : ST_ARM;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tmr_q   <= (state_q == ST_LOW) ? tmr_q + 1'b1 : '0;
      if (state_q == ST_IDLE && start_i)         done_q <= 1'b0;
      else if (state_q == ST_SPEED && last_i)    done_q <= 1'b1;
    end
  end

  assign load_o  = (state_q == ST_IDLE) && start_i;
  assign shift_o = (state_q == ST_SPEED);
  assign oe_o    = (state_q == ST_LOW) || (state_q == ST_SPEED);
  assign do_o    = (state_q == ST_SPEED);
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;

  assert_done_after_speed_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(do_o) && !busy_o);
  assert_arm_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && $past(state_q) == ST_ARM) |-> $past(line_s_i));
  assert_busy_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> !load_o && busy_o);
endmodule

// File: rtl/dbg_bit_tx.sv
module dbg_bit_tx #(
  parameter int WORD_W      = 16,
  parameter int LOW_CYC     = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              line_oe_o,
  output logic              line_do_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int RUN_W = $clog2(LOW_CYC + 2);

  logic line_s_w, fall_w, bit_w, last_w, load_w, shift_w;

  dbgtx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .line_i,
    .line_s_o(line_s_w), .fall_o(fall_w)
  );

  dbgtx_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i, .rst_ni,
    .load_i(load_w), .word_i, .shift_i(shift_w),
    .bit_o(bit_w), .last_o(last_w)
  );

  dbgtx_fsm #(.LOW_CYC(LOW_CYC)) u_fsm (
    .clk_i, .rst_ni, .start_i,
    .line_s_i(line_s_w), .fall_i(fall_w),
    .bit_i(bit_w), .last_i(last_w),
    .load_o(load_w), .shift_o(shift_w),
    .oe_o(line_oe_o), .do_o(line_do_o),
    .busy_o, .done_o
  );

  // run length of the low drive, for the hold-time check
  logic             low_now;
  logic [RUN_W-1:0] low_run_q;
  assign low_now = line_oe_o && !line_do_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      low_run_q <= '0;
    else if (low_now) low_run_q <= low_run_q + 1'b1;
    else              low_run_q <= '0;
  end

  assert_low_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!low_now && low_run_q != '0) |-> low_run_q == RUN_W'(LOW_CYC));
  assert_speedup_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_oe_o && line_do_o) |=> !line_oe_o);
  assert_drive_after_fall_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(line_oe_o) |-> $past(fall_w));
  assert_value_gated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_oe_o |-> !line_do_o);
endmodule

// File: tb/dbg_bit_tx_tb_top.sv
module dbg_bit_tx_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] word_i = '0;
  logic        host_low = 1'b0;
  logic        line_oe_o, line_do_o, busy_o, done_o;
  logic        line_w;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          fin = 1'b0;

  always #5 clk_i = ~clk_i;

  // open-drain line: host pull-down wins, else target drive, else pull-up
  assign line_w = host_low ? 1'b0 : (line_oe_o ? line_do_o : 1'b1);

  dbg_bit_tx dut_i (
    .clk_i, .rst_ni, .line_i(line_w), .start_i, .word_i,
    .line_oe_o, .line_do_o, .busy_o, .done_o
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // j = negedges after the host pull
  function automatic logic exp_oe(input logic b, input int j);
    return b ? (j == 3) : (j >= 3 && j <= 16);
  endfunction
  function automatic logic exp_do(input logic b, input int j);
    return b ? (j == 3) : (j == 16);
  endfunction

  task automatic host_bit(input logic b, input int hold, input bit collide, output bit ok);
    int win;
    int bad_j;
    int act;
    int exp;
    win   = ((hold > 4) ? hold : 4) + 18;
    bad_j = -1;
    act   = 0;
    exp   = 0;
    host_low = 1'b1;
    for (int j = 1; j <= win; j++) begin
      @(negedge clk_i);
      if (j == hold) host_low = 1'b0;
      if (collide && (j == 8 || j == 16)) host_low = 1'b1;
      if (collide && (j == 9 || j == 17)) host_low = 1'b0;
      if (bad_j < 0 && (line_oe_o !== exp_oe(b, j) || line_do_o !== exp_do(b, j))) begin
        bad_j = j;
        act   = {line_oe_o, line_do_o};
        exp   = {exp_oe(b, j), exp_do(b, j)};
      end
      if (j == 10 && hold < 10)
        check(line_w === b, "R5", "line level at host sample", line_w, b);
    end
    if (collide)
      check(bad_j < 0, "R6", "drive pattern with host edges during drive", act, exp);
    else if (hold > 10)
      check(bad_j < 0, "R7", "drive pattern with long host hold", act, exp);
    else
      check(bad_j < 0, b ? "R4" : "R2", "bit drive pattern (oe,do) incl speedup R3", act, exp);
    ok = (bad_j < 0);
  endtask

  task automatic send_word(input logic [15:0] w, input int mode);
    bit collided;
    bit ok;
    bit after_ok;
    int hold;
    bit col;
    collided = 1'b0;
    after_ok = 1'b1;
    @(negedge clk_i);
    start_i = 1'b1;
    word_i  = w;
    @(negedge clk_i);
    start_i = 1'b0;
    word_i  = '0;
    check(busy_o === 1'b1 && done_o === 1'b0, "R9", "busy/done after start",
          {busy_o, done_o}, 2);
    repeat (3) @(negedge clk_i);
    for (int i = 0; i < 16; i++) begin
      hold = (mode == 1 && i == 4) ? 25 : 1 + int'($urandom % 3);
      col  = (mode == 2) && !collided && i >= 4 && !w[15-i];
      host_bit(w[15-i], hold, col, ok);
      check(ok, "R8", $sformatf("bit %0d of word in order", 15 - i), ok, 1);
      if (col) collided = 1'b1;
      if (mode == 3 && i > 7) after_ok &= ok;
      if (mode == 3 && i == 7) begin
        start_i = 1'b1;
        word_i  = ~w;
        @(negedge clk_i);
        start_i = 1'b0;
        check(busy_o === 1'b1, "R10", "busy after start while busy", busy_o, 1);
      end
      repeat (int'($urandom % 4)) @(negedge clk_i);
    end
    if (mode == 3) check(after_ok, "R10", "word unchanged after late start", after_ok, 1);
    if (mode == 2) check(collided, "R6", "collision case provoked", collided, 1);
    check(done_o === 1'b1 && busy_o === 1'b0, "R9", "done/busy after last bit",
          {done_o, busy_o}, 2);
    check(line_oe_o === 1'b0, "R3", "line released after word", line_oe_o, 0);
  endtask

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk_i);
    check({line_oe_o, line_do_o, busy_o, done_o} === 4'b0, "R11", "outputs in reset",
          {line_oe_o, line_do_o, busy_o, done_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check({line_oe_o, line_do_o, busy_o, done_o} === 4'b0, "R11", "outputs after reset",
          {line_oe_o, line_do_o, busy_o, done_o}, 0);
    // R1: a host edge while idle produces no drive
    host_low = 1'b1;
    repeat (2) @(negedge clk_i);
    host_low = 1'b0;
    repeat (4) @(negedge clk_i);
    check(line_oe_o === 1'b0 && busy_o === 1'b0, "R1", "no drive while idle",
          line_oe_o, 0);
    send_word(16'h8001, 0);
    send_word(16'hFFFF, 1);
    send_word(16'h0000, 1);
    send_word(16'h00F0, 2);
    send_word(16'($urandom), 3);
    for (int k = 0; k < 3; k++) send_word(16'($urandom), 0);
    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!fin) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule